// File: doc/BRIEF.md
# Write-Once Fuse Array Controller

This block manages a one-time-programmable fuse array of 32-bit words behind a simple register bus. Software chooses a target with a word-select register and a bit-select register, and puts the value to burn into a data register. It then writes 1 to the burn-strobe register. That write programs one single bit of the array. Each bit has its own sticky "already burned" flag. A second attempt on the same bit leaves the array unchanged and raises an error flag, and it does so whatever the value asked for.

The bus is single-cycle. A write is taken on the clock edge where `bus_we` is high. Read data is a combinational function of `bus_addr`. A fuse-view register returns the whole word chosen by the word-select register. At reset every burned flag is cleared. A configured serial number is loaded into one word and its bitwise complement into the word that follows. Every other word reads 0.

Top module: `otp_wo_ctrl`

## Requirements
- R1: After reset, the status register and every control register read 0, and all burned flags are clear. Word SERIAL_WORD holds SERIAL, word SERIAL_WORD+1 holds ~SERIAL, and every other word holds 0.
- R2: The word-select register (offset 0x00) keeps bits [15:0] of the written value. The bit-select register (0x04) keeps bits [4:0]. The burn-data register (0x08) keeps bit 0. The spare-cell select register (0x0C) keeps bit 0. Each register reads back what it keeps, with zeros above.
- R3: The trim register at offset 0x34 stores and returns all 32 bits written to it.
- R4: The burn-strobe register at offset 0x38 keeps only bit 0 of a write and reads back 0 in bits [31:1].
- R5: A burn is attempted only on a write to 0x38 whose bit 0 is 1 while the spare-cell select register reads 0. Any other write changes no fuse bit and no burned flag.
- R6: An attempt on a bit whose flag is clear sets that fuse bit to the burn-data value and sets its flag, whether the value is 0 or 1. A read of the fuse-view register (0x10) in the next cycle returns the new word.
- R7: An attempt on a bit whose flag is already set leaves the fuse word unchanged and sets bit 0 of the status register (0x14).
- R8: An attempt with a word select of NUM_WORDS or more changes nothing in the array and sets status bit 0. The fuse-view register reads 0 while the word select is out of range.
- R9: Status bit 0 stays set until a write to 0x14 with bit 0 equal to 1. A write there with bit 0 equal to 0 leaves it unchanged.
- R10: Reads at offsets other than 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x34 and 0x38 return 0. Writes there change no register and no fuse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |

## Verification
Some rules are checked by the assertions on every cycle. Array storage never acts without a burn request (R5). A burn is never both committed and rejected. Every rejection sets the status flag in the next cycle (R7). The flag is only released by a write of 1 (R9). The upper bits of the burn-strobe register stay zero (R4), and an undefined offset reads zero (R10). Other behaviour can only be shown by the bench's scenarios, which compare values against a model. These are: which bit actually changes and to what value, that a bit burned to 0 is still locked, that the spare-cell select blocks a burn without touching the flag, the reset contents of the serial words, and out-of-range rejection.

// File: rtl/otp_wo_pkg.sv
package otp_wo_pkg;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 8;
   localparam int BO_W   = $clog2(DATA_W);

   localparam logic [ADDR_W-1:0] OFS_WSEL  = 8'h00;
   localparam logic [ADDR_W-1:0] OFS_BSEL  = 8'h04;
   localparam logic [ADDR_W-1:0] OFS_BDAT  = 8'h08;
   localparam logic [ADDR_W-1:0] OFS_SPARE = 8'h0C;
   localparam logic [ADDR_W-1:0] OFS_FVIEW = 8'h10;
   localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h14;
   localparam logic [ADDR_W-1:0] OFS_TRIM  = 8'h34;
   localparam logic [ADDR_W-1:0] OFS_BURN  = 8'h38;
endpackage

// File: rtl/otp_reg_file.sv
module otp_reg_file
   import otp_wo_pkg::*;
#(
   parameter int WA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [WA_W-1:0]   wsel_o,
   output logic [BO_W-1:0]   bsel_o,
   output logic              bdat_o,
   output logic              burn_req_o,
   output logic              err_o,
   input  logic              reject_i,
   input  logic [DATA_W-1:0] fuse_word_i
);
   logic [WA_W-1:0]   wsel_q;
   logic [BO_W-1:0]   bsel_q;
   logic              bdat_q;
   logic              spare_q;
   logic              burn_q;
   logic              err_q;
   logic [DATA_W-1:0] trim_q;
   logic              err_clr;

   assign err_clr    = bus_we && (bus_addr == OFS_STAT) && bus_wdata[0];
   assign burn_req_o = bus_we && (bus_addr == OFS_BURN) && bus_wdata[0] && !spare_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wsel_q  <= '0;
         bsel_q  <= '0;
         bdat_q  <= 1'b0;
         spare_q <= 1'b0;
         burn_q  <= 1'b0;
         err_q   <= 1'b0;
         trim_q  <= '0;
      end else begin
         if (bus_we) begin
            case (bus_addr)
               OFS_WSEL:  wsel_q  <= bus_wdata[WA_W-1:0];
               OFS_BSEL:  bsel_q  <= bus_wdata[BO_W-1:0];
               OFS_BDAT:  bdat_q  <= bus_wdata[0];
               OFS_SPARE: spare_q <= bus_wdata[0];
               OFS_TRIM:  trim_q  <= bus_wdata;
               OFS_BURN:  burn_q  <= bus_wdata[0];
               default: ;
            endcase
         end
         err_q <= (err_q && !err_clr) || reject_i;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFS_WSEL:  bus_rdata[WA_W-1:0] = wsel_q;
         OFS_BSEL:  bus_rdata[BO_W-1:0] = bsel_q;
         OFS_BDAT:  bus_rdata[0]        = bdat_q;
         OFS_SPARE: bus_rdata[0]        = spare_q;
         OFS_FVIEW: bus_rdata           = fuse_word_i;
         OFS_STAT:  bus_rdata[0]        = err_q;
         OFS_TRIM:  bus_rdata           = trim_q;
         OFS_BURN:  bus_rdata[0]        = burn_q;
         default:   bus_rdata           = '0;
      endcase
   end

   assign wsel_o = wsel_q;
   assign bsel_o = bsel_q;
   assign bdat_o = bdat_q;
   assign err_o  = err_q;
endmodule

// File: rtl/otp_fuse_store.sv
module otp_fuse_store
   import otp_wo_pkg::*;
#(
   parameter int          NUM_WORDS   = 1024,
   parameter int          WA_W        = 16,
   parameter logic [31:0] SERIAL      = 32'hA5C3_0F96,
   parameter int          SERIAL_WORD = 252
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              burn_req_i,
   input  logic [WA_W-1:0]   wsel_i,
   input  logic [BO_W-1:0]   bsel_i,
   input  logic              bdat_i,
   output logic [DATA_W-1:0] word_o,
   output logic              commit_o,
   output logic              reject_o
);
   localparam int AW = $clog2(NUM_WORDS);

   if (NUM_WORDS < 2 || NUM_WORDS > (1 << WA_W))
      $error("NUM_WORDS must lie between 2 and 2**WA_W");
   if (SERIAL_WORD < 0 || SERIAL_WORD + 1 >= NUM_WORDS)
      $error("SERIAL_WORD and the word after it must lie inside the array");

   logic              in_range;
   logic [AW-1:0]     idx;
   logic [DATA_W-1:0] fuse_all [NUM_WORDS];
   logic [DATA_W-1:0] flag_all [NUM_WORDS];
   logic              flag_hit;

   assign idx = wsel_i[AW-1:0];

   if (NUM_WORDS == (1 << WA_W)) begin : g_full_range
      assign in_range = 1'b1;
   end else begin : g_range_cmp
      localparam logic [WA_W:0] LIMIT = (WA_W+1)'(NUM_WORDS);
      assign in_range = ({1'b0, wsel_i} < LIMIT);
   end

   assign flag_hit = in_range && flag_all[idx][bsel_i];
   assign word_o   = in_range ? fuse_all[idx] : '0;
   assign commit_o = burn_req_i && in_range && !flag_hit;
   assign reject_o = burn_req_i && !(in_range && !flag_hit);

   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_row
      localparam logic [DATA_W-1:0] RST_VAL =
         (i == SERIAL_WORD)     ? SERIAL  :
         (i == SERIAL_WORD + 1) ? ~SERIAL : '0;
      logic [DATA_W-1:0] fz_q;
      logic [DATA_W-1:0] wf_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            fz_q <= RST_VAL;
            wf_q <= '0;
         end else if (commit_o && (idx == AW'(i))) begin
            fz_q[bsel_i] <= bdat_i;
            wf_q[bsel_i] <= 1'b1;
         end
      end

      assign fuse_all[i] = fz_q;
      assign flag_all[i] = wf_q;
   end
endmodule

// File: rtl/otp_wo_ctrl.sv
module otp_wo_ctrl
   import otp_wo_pkg::*;
#(
   parameter int          NUM_WORDS   = 1024,
   parameter int          WA_W        = 16,
   parameter logic [31:0] SERIAL      = 32'hA5C3_0F96,
   parameter int          SERIAL_WORD = 252
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_we,
   input  logic [7:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata
);
   logic [WA_W-1:0]   wsel;
   logic [BO_W-1:0]   bsel;
   logic              bdat;
   logic              burn_req;
   logic              err_flag;
   logic              commit;
   logic              reject;
   logic [DATA_W-1:0] fuse_word;

   otp_reg_file #(.WA_W(WA_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_we      (bus_we),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .wsel_o      (wsel),
      .bsel_o      (bsel),
      .bdat_o      (bdat),
      .burn_req_o  (burn_req),
      .err_o       (err_flag),
      .reject_i    (reject),
      .fuse_word_i (fuse_word)
   );

   otp_fuse_store #(
      .NUM_WORDS   (NUM_WORDS),
      .WA_W        (WA_W),
      .SERIAL      (SERIAL),
      .SERIAL_WORD (SERIAL_WORD)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .burn_req_i (burn_req),
      .wsel_i     (wsel),
      .bsel_i     (bsel),
      .bdat_i     (bdat),
      .word_o     (fuse_word),
      .commit_o   (commit),
      .reject_o   (reject)
   );
endmodule

// File: rtl/otp_wo_ctrl_chk.sv
module otp_wo_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        bus_we,
   input logic [7:0]  bus_addr,
   input logic        wdata0,
   input logic [31:0] bus_rdata,
   input logic        burn_req,
   input logic        commit,
   input logic        reject,
   input logic        err_flag
);
   p_no_act_without_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !burn_req |-> (!commit && !reject));

   p_commit_reject_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(commit && reject));

   p_reject_raises_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
      reject |=> err_flag);

   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !(bus_we && bus_addr == 8'h14 && wdata0)) |=> err_flag);

   p_burn_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 8'h38) |-> (bus_rdata[31:1] == 31'd0));

   p_undef_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 8'h20 || bus_addr == 8'h3C) |-> (bus_rdata == 32'd0));
endmodule

bind otp_wo_ctrl otp_wo_ctrl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .wdata0    (bus_wdata[0]),
   .bus_rdata (bus_rdata),
   .burn_req  (burn_req),
   .commit    (commit),
   .reject    (reject),
   .err_flag  (err_flag)
);

// File: tb/otp_wo_ctrl_bench.sv
`timescale 1ns/1ps
module otp_wo_ctrl_bench;
   localparam int          NW  = 1024;
   localparam int          SW  = 252;
   localparam logic [31:0] SER = 32'hA5C3_0F96;

   localparam logic [7:0] A_WSEL = 8'h00, A_BSEL = 8'h04, A_BDAT = 8'h08, A_SPARE = 8'h0C;
   localparam logic [7:0] A_FVIEW = 8'h10, A_STAT = 8'h14, A_TRIM = 8'h34, A_BURN = 8'h38;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   always #2 clk = ~clk;

   otp_wo_ctrl #(.NUM_WORDS(NW), .SERIAL(SER), .SERIAL_WORD(SW)) u_otp_wo_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   typedef struct {
      logic [7:0]  a;
      logic [31:0] e;
      string       tag;
   } item_t;
   item_t sbq[$];

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [31:0] mf [NW];
   logic [31:0] mw [NW];
   logic [15:0] m_wsel = '0;
   logic [4:0]  m_bsel = '0;
   logic        m_bdat = 1'b0, m_spare = 1'b0, m_burn = 1'b0, m_err = 1'b0;
   logic [31:0] m_trim = '0;

   function automatic logic [31:0] model_rd(logic [7:0] a);
      case (a)
         A_WSEL:  return {16'd0, m_wsel};
         A_BSEL:  return {27'd0, m_bsel};
         A_BDAT:  return {31'd0, m_bdat};
         A_SPARE: return {31'd0, m_spare};
         A_FVIEW: return (int'(m_wsel) < NW) ? mf[m_wsel] : 32'd0;
         A_STAT:  return {31'd0, m_err};
         A_TRIM:  return m_trim;
         A_BURN:  return {31'd0, m_burn};
         default: return 32'd0;
      endcase
   endfunction

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      case (a)
         A_WSEL:  m_wsel  = d[15:0];
         A_BSEL:  m_bsel  = d[4:0];
         A_BDAT:  m_bdat  = d[0];
         A_SPARE: m_spare = d[0];
         A_STAT:  if (d[0]) m_err = 1'b0;
         A_TRIM:  m_trim  = d;
         A_BURN: begin
            if (d[0] && !m_spare) begin
               if (int'(m_wsel) >= NW || mw[m_wsel][m_bsel]) m_err = 1'b1;
               else begin
                  mf[m_wsel][m_bsel] = m_bdat;
                  mw[m_wsel][m_bsel] = 1'b1;
               end
            end
            m_burn = d[0];
         end
         default: ;
      endcase
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
      item_t it;
      it.a = a; it.e = e; it.tag = tag;
      bus_we = 1'b0; bus_addr = a;
      sbq.push_back(it);
      @(posedge clk); #1;
   endtask

   task automatic rd(input logic [7:0] a, input string tag);
      rd_exp(a, model_rd(a), tag);
   endtask

   always @(negedge clk) begin
      if (sbq.size() > 0) begin
         item_t it;
         it = sbq.pop_front();
         n_chk++;
         if (bus_rdata !== it.e) begin
            n_fail++;
            $display("FAIL %s: addr %h got %h expected %h", it.tag, it.a, bus_rdata, it.e);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NW; i++) begin
         mf[i] = (i == SW) ? SER : (i == SW + 1) ? ~SER : 32'd0;
         mw[i] = 32'd0;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 reset contents
      rd_exp(A_STAT, 32'd0, "R1 status");
      rd_exp(A_TRIM, 32'd0, "R1 trim");
      rd_exp(A_BURN, 32'd0, "R1 burn");
      wr(A_WSEL, SW);
      rd_exp(A_FVIEW, SER, "R1 serial word");
      wr(A_WSEL, SW + 1);
      rd_exp(A_FVIEW, ~SER, "R1 complement word");
      wr(A_WSEL, 5);
      rd_exp(A_FVIEW, 32'd0, "R1 plain word");

      // R2 register widths
      wr(A_BSEL, 32'h25);
      rd_exp(A_BSEL, 32'd5, "R2 bit select");
      wr(A_WSEL, 32'hABCD_0123);
      rd_exp(A_WSEL, 32'h0000_0123, "R2 word select");
      wr(A_BDAT, 32'hFF);
      rd_exp(A_BDAT, 32'd1, "R2 burn data");

      // R3 trim
      wr(A_TRIM, 32'hDEAD_BEEF);
      rd_exp(A_TRIM, 32'hDEAD_BEEF, "R3 trim");

      // R4 strobe keeps bit 0 only, no burn with bit 0 clear
      wr(A_WSEL, 5); wr(A_BSEL, 3);
      wr(A_BURN, 32'hFFFF_FFFE);
      rd_exp(A_BURN, 32'd0, "R4 strobe bit0 only");
      rd_exp(A_FVIEW, 32'd0, "R5 strobe 0 no burn");

      // R6 fresh bit burned to 1
      wr(A_BDAT, 1); wr(A_BURN, 1);
      rd_exp(A_FVIEW, 32'h0000_0008, "R6 burn bit 3");
      rd_exp(A_STAT, 32'd0, "R6 no error");
      rd_exp(A_BURN, 32'd1, "R4 strobe readback");

      // R7 second attempt
      wr(A_BDAT, 0); wr(A_BURN, 1);
      rd_exp(A_FVIEW, 32'h0000_0008, "R7 word unchanged");
      rd_exp(A_STAT, 32'd1, "R7 error set");

      // R9 sticky, write-1 clear
      wr(A_STAT, 0);
      rd_exp(A_STAT, 32'd1, "R9 write 0 keeps");
      wr(A_STAT, 1);
      rd_exp(A_STAT, 32'd0, "R9 write 1 clears");

      // R6 bit burned to 0 is then locked
      wr(A_BSEL, 31); wr(A_BDAT, 0); wr(A_BURN, 1);
      rd_exp(A_STAT, 32'd0, "R6 zero burn accepted");
      wr(A_BDAT, 1); wr(A_BURN, 1);
      rd_exp(A_FVIEW, 32'h0000_0008, "R7 zero-burned bit locked");
      rd_exp(A_STAT, 32'd1, "R7 error on zero-burned bit");
      wr(A_STAT, 1);

      // R5 spare-cell select blocks a burn
      wr(A_SPARE, 1); wr(A_BSEL, 0); wr(A_BDAT, 1); wr(A_BURN, 1);
      rd_exp(A_FVIEW, 32'h0000_0008, "R5 spare blocks burn");
      rd_exp(A_STAT, 32'd0, "R5 spare no error");
      wr(A_SPARE, 0); wr(A_BURN, 1);
      rd_exp(A_FVIEW, 32'h0000_0009, "R5 flag untouched");

      // R8 out of range
      wr(A_WSEL, NW); wr(A_BURN, 1);
      rd_exp(A_STAT, 32'd1, "R8 range error");
      rd_exp(A_FVIEW, 32'd0, "R8 view reads 0");
      wr(A_STAT, 1);
      wr(A_WSEL, NW - 1);
      rd_exp(A_FVIEW, 32'd0, "R8 last word untouched");

      // R6 serial bit burned to 0
      wr(A_WSEL, SW); wr(A_BSEL, 1); wr(A_BDAT, 0); wr(A_BURN, 1);
      rd_exp(A_FVIEW, SER & ~32'd2, "R6 serial bit");

      // R10 undefined offsets
      wr(8'h20, 32'hFFFF_FFFF);
      wr(8'h35, 32'hFFFF_FFFF);
      rd_exp(8'h20, 32'd0, "R10 read 0x20");
      rd_exp(8'h3C, 32'd0, "R10 read 0x3C");
      rd_exp(A_TRIM, 32'hDEAD_BEEF, "R10 trim kept");
      rd_exp(A_WSEL, SW, "R10 word select kept");
      rd_exp(A_FVIEW, SER & ~32'd2, "R10 fuse kept");

      // R6 R7 sweep against the model
      for (int i = 0; i < 48; i++) begin
         wr(A_WSEL, (i * 37) % NW);
         wr(A_BSEL, (i * 7) % 32);
         wr(A_BDAT, i % 2);
         wr(A_BURN, 1);
         if (i % 3 == 0) begin
            wr(A_BDAT, (i + 1) % 2);
            wr(A_BURN, 1);
         end
         rd(A_FVIEW, "R6 sweep word");
         rd(A_STAT, "R7 sweep status");
         wr(A_STAT, 1);
      end

      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule